// File: doc/BRIEF.md
# Opcode-Driven Arithmetic Logic Unit

This block is a purely combinational arithmetic-logic unit for a datapath that works on two's-complement words (32 bits by default). A 4-bit operation code picks one of ten functions: addition, subtraction, NAND, OR, bitwise inversion of the first operand, one-position arithmetic and logical right shifts, a one-position left shift, and one-position rotates in either direction. Shifts and rotates act on operand A only. There is no shift amount input.

Each evaluation produces a result word and three flags: zero, carry-out and signed overflow. Carry and overflow only have meaning for addition and subtraction. For every other code they are held low. The six operation codes that are not assigned give a defined all-zero result, so an illegal code can never leak stale or partial data downstream.

Top module: `opc_alu`

## Requirements
- R1: Code 4'b0000 gives res = A + B modulo 2^W, and carry = the carry out of bit W-1.
- R2: Code 4'b0001 gives res = A - B modulo 2^W, and carry = 1 exactly when no borrow occurs, that is when A >= B as unsigned values.
- R3: For add, overflow = 1 exactly when A and B share a sign bit that differs from the result's sign bit. For subtract, overflow = 1 exactly when A and B differ in sign and the result's sign differs from A's sign.
- R4: Code 4'b0010 gives res = NOT(A AND B). Code 4'b0011 gives res = A OR B.
- R5: Code 4'b0100 gives res = bitwise inverse of A. B has no effect on the result.
- R6: Code 4'b1000 shifts A right by one position and copies the old bit W-1 into the new bit W-1.
- R7: Code 4'b1001 shifts A right by one position with a 0 entering bit W-1. Code 4'b1010 shifts A left by one position with a 0 entering bit 0.
- R8: Code 4'b1100 rotates A left by one, so the old bit W-1 lands in bit 0. Code 4'b1101 rotates A right by one, so the old bit 0 lands in bit W-1.
- R9: The zero flag is 1 exactly when every result bit is 0, under every operation code.
- R10: The codes 0101, 0110, 0111, 1011, 1110 and 1111 give an all-zero result, with carry and overflow at 0.
- R11: For every code other than 0000 and 0001, carry and overflow are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand, two's complement; the only source for inversion, shifts and rotates |
| b_i | input | W | Second operand, two's complement |
| op_i | input | 4 | Operation code |
| res_o | output | W | Result word |
| zero_o | output | 1 | High when res_o is all zeros |
| cout_o | output | 1 | Carry out for add; no-borrow for subtract; 0 otherwise |
| ovf_o | output | 1 | Signed overflow for add and subtract; 0 otherwise |

## Verification
The bound checker evaluates immediate assertions whenever the inputs settle. These assertions assume that operands and the operation code are fully known (no X or Z) and that the inputs change as a group, not bit by bit across the settle point.

The bench meets both assumptions. It drives every input from a single task right after a rising clock edge, always with fully defined values, and reads the outputs only at the following falling edge. All sixteen operation codes are applied, the unassigned ones included. They are crossed with a fixed set of operand extremes (zero, one, all ones, most positive, most negative, alternating patterns) and with a stream of pseudo-random pairs.

// File: rtl/opc_alu_pkg.sv
package opc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_SUB  = 4'b0001,
    OP_NAND = 4'b0010,
    OP_OR   = 4'b0011,
    OP_INV  = 4'b0100,
    OP_SRA  = 4'b1000,
    OP_SRL  = 4'b1001,
    OP_SLL  = 4'b1010,
    OP_ROL  = 4'b1100,
    OP_ROR  = 4'b1101
  } alu_op_e;

  function automatic logic op_is_arith(input logic [3:0] code);
    return (code == OP_ADD) || (code == OP_SUB);
  endfunction

  function automatic logic op_is_known(input logic [3:0] code);
    case (code)
      OP_ADD, OP_SUB, OP_NAND, OP_OR, OP_INV,
      OP_SRA, OP_SRL, OP_SLL, OP_ROL, OP_ROR: return 1'b1;
      default:                                return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/opc_alu_addsub.sv
module opc_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);

  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   total;

  // One adder serves both operations: subtraction is A + ~B + 1.
  always_comb begin
    b_eff = b_i ^ {W{sub_i}};
    total = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  end

  assign sum_o   = total[MSB:0];
  assign carry_o = total[W];
  // Operands (after B conditioning) agree in sign, result does not.
  assign ovf_o   = (a_i[MSB] == b_eff[MSB]) && (total[MSB] != a_i[MSB]);

endmodule

// File: rtl/opc_alu_logic.sv
module opc_alu_logic
  import opc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] out_o
);

  always_comb begin
    case (op_i)
      OP_NAND: out_o = ~(a_i & b_i);
      OP_OR:   out_o = a_i | b_i;
      OP_INV:  out_o = ~a_i;
      default: out_o = '0;
    endcase
  end

endmodule

// File: rtl/opc_alu_shift.sv
module opc_alu_shift
  import opc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] out_o
);

  localparam int MSB = W - 1;

  logic go_left;
  logic fill_lo;   // bit entering position 0 on a left move
  logic fill_hi;   // bit entering position MSB on a right move
  logic active;

  always_comb begin
    go_left = 1'b0;
    fill_lo = 1'b0;
    fill_hi = 1'b0;
    active  = 1'b1;
    case (op_i)
      OP_SRA:  fill_hi = a_i[MSB];
      OP_SRL:  fill_hi = 1'b0;
      OP_SLL:  go_left = 1'b1;
      OP_ROL:  begin go_left = 1'b1; fill_lo = a_i[MSB]; end
      OP_ROR:  fill_hi = a_i[0];
      default: active = 1'b0;
    endcase
  end

  // Each output bit picks its lower or upper neighbour.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic from_lo;
    logic from_hi;
    if (i == 0) begin : g_lsb
      assign from_lo = fill_lo;
    end else begin : g_mid_lo
      assign from_lo = a_i[i-1];
    end
    if (i == MSB) begin : g_msb
      assign from_hi = fill_hi;
    end else begin : g_mid_hi
      assign from_hi = a_i[i+1];
    end
    assign out_o[i] = active & (go_left ? from_lo : from_hi);
  end

endmodule

// File: rtl/opc_alu_chk.sv
module opc_alu_chk
  import opc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] res_o,
  input logic         zero_o,
  input logic         cout_o,
  input logic         ovf_o
);

  localparam int MSB = W - 1;

  always_comb begin
    if (op_i == OP_ADD && ovf_o)
      p_add_ovf_sign_r3: assert (a_i[MSB] == b_i[MSB] && res_o[MSB] != a_i[MSB])
        else $error("add overflow without sign condition");
    if (op_i == OP_SUB && ovf_o)
      p_sub_ovf_sign_r3: assert (a_i[MSB] != b_i[MSB] && res_o[MSB] != a_i[MSB])
        else $error("sub overflow without sign condition");
    if (!op_is_arith(op_i))
      p_no_flags_r11: assert (!cout_o && !ovf_o)
        else $error("carry/overflow set on non-arithmetic code");
    if (!op_is_known(op_i))
      p_undef_zero_r10: assert (res_o == '0 && zero_o)
        else $error("unassigned code produced data");
    if (op_i == OP_INV && zero_o)
      p_inv_zero_r5: assert (&a_i)
        else $error("inversion zero with A not all ones");
    if (op_i == OP_SRA)
      p_sra_sign_r6: assert (res_o[MSB] == a_i[MSB] && res_o[MSB-1] == a_i[MSB])
        else $error("arithmetic shift lost sign");
    if (op_i == OP_ROL)
      p_rol_wrap_r8: assert (res_o[0] == a_i[MSB] && res_o[MSB] == a_i[MSB-1])
        else $error("rotate left wrap wrong");
    if (op_i == OP_ROR)
      p_ror_wrap_r8: assert (res_o[MSB] == a_i[0] && res_o[0] == a_i[1])
        else $error("rotate right wrap wrong");
  end

endmodule

bind opc_alu opc_alu_chk #(.W(W)) chk_i (
  .a_i   (a_i),
  .b_i   (b_i),
  .op_i  (op_i),
  .res_o (res_o),
  .zero_o(zero_o),
  .cout_o(cout_o),
  .ovf_o (ovf_o)
);

// File: rtl/opc_alu.sv
module opc_alu
  import opc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         cout_o,
  output logic         ovf_o
);

  logic [W-1:0] sum_w;
  logic [W-1:0] logic_w;
  logic [W-1:0] shift_w;
  logic         carry_w;
  logic         ovf_w;
  logic         arith_w;

  assign arith_w = op_is_arith(op_i);

  opc_alu_addsub #(.W(W)) addsub_i (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (op_i == OP_SUB),
    .sum_o  (sum_w),
    .carry_o(carry_w),
    .ovf_o  (ovf_w)
  );

  opc_alu_logic #(.W(W)) logic_i (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (op_i),
    .out_o(logic_w)
  );

  opc_alu_shift #(.W(W)) shift_i (
    .a_i  (a_i),
    .op_i (op_i),
    .out_o(shift_w)
  );

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB:                         res_o = sum_w;
      OP_NAND, OP_OR, OP_INV:                 res_o = logic_w;
      OP_SRA, OP_SRL, OP_SLL, OP_ROL, OP_ROR: res_o = shift_w;
      default:                                res_o = '0;
    endcase
  end

  assign zero_o = ~|res_o;
  assign cout_o = arith_w & carry_w;
  assign ovf_o  = arith_w & ovf_w;

endmodule

// File: tb/opc_alu_tb_top.sv
module opc_alu_tb_top;

  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a, b;
  logic [3:0]   op;
  logic [W-1:0] res;
  logic         zero, cout, ovf;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  opc_alu #(.W(W)) dut_i (
    .a_i(a), .b_i(b), .op_i(op),
    .res_o(res), .zero_o(zero), .cout_o(cout), .ovf_o(ovf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  // Requirement tag for the result of each code.
  function automatic string res_tag(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010, 4'b0011: return "R4";
      4'b0100: return "R5";
      4'b1000: return "R6";
      4'b1001, 4'b1010: return "R7";
      4'b1100, 4'b1101: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s op=%b a=%h b=%h: actual=%h expected=%h",
               tag, what, op, a, b, act, exp);
    end
  endtask

  task automatic run_vec(input logic [3:0] c, input logic [W-1:0] va,
                         input logic [W-1:0] vb);
    logic [W-1:0] e_res;
    logic         e_c, e_v;
    longint       ua, ub, sa, sb, s;
    @(posedge clk);
    op = c; a = va; b = vb;
    ua = longint'({32'b0, va});
    ub = longint'({32'b0, vb});
    sa = longint'($signed(va));
    sb = longint'($signed(vb));
    e_c = 1'b0; e_v = 1'b0;
    case (c)
      4'b0000: begin
        e_res = W'(ua + ub); e_c = (ua + ub) >= 64'sh1_0000_0000;
        s = sa + sb; e_v = (s > 64'sh7FFF_FFFF) || (s < -64'sh8000_0000);
      end
      4'b0001: begin
        e_res = W'(ua - ub); e_c = (ua >= ub);
        s = sa - sb; e_v = (s > 64'sh7FFF_FFFF) || (s < -64'sh8000_0000);
      end
      4'b0010: e_res = ~(va & vb);
      4'b0011: e_res = va | vb;
      4'b0100: e_res = ~va;
      4'b1000: e_res = W'(sa / 2 - ((sa < 0 && sa % 2 != 0) ? 1 : 0));
      4'b1001: e_res = W'(ua / 2);
      4'b1010: e_res = W'(ua * 2);
      4'b1100: e_res = W'(ua * 2) | W'(ua / 64'sh8000_0000);
      4'b1101: e_res = W'(ua / 2) | (W'(ua % 2) << (W - 1));
      default: e_res = '0;
    endcase
    @(negedge clk);
    check(res_tag(c), "result", res, e_res);
    check("R9", "zero", W'(zero), W'(e_res == '0));
    check((c == 4'b0000 || c == 4'b0001) ? "R1/R2" : "R11", "carry", W'(cout), W'(e_c));
    check((c == 4'b0000 || c == 4'b0001) ? "R3" : "R11", "overflow", W'(ovf), W'(e_v));
  endtask

  logic [W-1:0] corner [10];
  logic [W-1:0] lfsr;

  initial begin
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h8000_0000; corner[5] = 32'h5555_5555;
    corner[6] = 32'hAAAA_AAAA; corner[7] = 32'h8000_0001;
    corner[8] = 32'h0001_0000; corner[9] = 32'hFFFF_0000;
    a = '0; b = '0; op = 4'b0000;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state: zero operands, add -> zero result, flags clear (R9, R1)
    check("R9", "idle zero", W'(zero), W'(1'b1));
    check("R1", "idle result", res, '0);

    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run_vec(4'(c), corner[i], corner[j]);

    lfsr = 32'hACE1_1234;
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] ra, rb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rb = lfsr ^ 32'h9E37_79B9;
      for (int c = 0; c < 16; c++)
        run_vec(4'(c), ra, rb);
    end

    // R5: B must not affect inversion; same A, two different B values
    run_vec(4'b0100, 32'h1234_5678, 32'h0000_0000);
    run_vec(4'b0100, 32'h1234_5678, 32'hFFFF_FFFF);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule